// File: doc/BRIEF.md
# Line-Sensor Timing Generator with Per-Pixel Integration Multiples

This block runs from a master clock and produces every strobe that a current-output linear photodiode array and its external readout chain need. It divides the master clock into a pixel clock, issues the start pulse that launches the sensor's internal shift register, and drives the active-low read-enable (inhibit) line. That line opens a pixel's address switch only inside a guarded window that is well clear of every pixel-clock falling edge. For the external charge integrator it issues an integrator reset, a clamp strobe right after that reset, and a sample trigger once the pixel's charge has been collected.

Each pixel has a programmable integration multiple M. The pixel is read on one line out of every M, and on the other lines its read-enable stays inactive, so its charge keeps building. Its integration time is therefore M start-pulse periods. A host loads the multiples through a single-cycle write port. Writes land in a shadow bank that is copied into the working bank only at a line boundary, or when a master start arrives. A master start restarts the whole sequence from its initial slot and clears every pixel's line counter.

A line is made of slots, each one pixel-clock period of DIV master ticks. The sequencer walks four named states. LEAD covers slot 0 and the first half of the start pulse. PIX covers slots 1..NPIX, one pixel per slot. EOS covers slot NPIX+1, the sensor's end-of-scan slot. PAD covers optional idle slots. The transitions are: LEAD→PIX at the end of slot 0; PIX→PIX from one pixel to the next; PIX→EOS after pixel NPIX; EOS→PAD, or EOS→LEAD when PAD_SLOTS is 0; PAD→LEAD after the last slot. A master start forces any state to LEAD.

Top module: `sens_tg`

## Requirements
- R1: Within every slot, the master-tick phase runs 0..DIV-1. `pix_clk` is low for phases below DIV/2 and high for the rest, so each slot starts with a falling edge and the duty cycle is 50 %.
- R2: `start_pulse` is high from phase DIV/2 of slot 0 to phase DIV/2-1 of slot 1, so exactly one falling edge of `pix_clk` occurs while it is high. It repeats every NPIX+2+PAD_SLOTS slots.
- R3: In the slot of pixel p (slot p, p = 1..NPIX), `inhibit` may be low only for phases GUARD..DIV-GUARD-1. It is therefore high for at least GUARD master ticks before and after every falling edge of `pix_clk`.
- R4: `inhibit` is high throughout slot 0, the end-of-scan slot NPIX+1 and every pad slot.
- R5: Pixel p (write address p-1) is read, meaning `inhibit` is low in its window, on line n counted from the last master start exactly when n mod M = 0. M is the 4-bit value written for that pixel; M = 0 acts as 1, and M = 15 is the longest interval. After reset every M is 1.
- R6: In a read pixel's slot, `integ_rst` pulses at phase 0, `clamp_stb` at phase 1 and `trig_stb` at phase DIV-GUARD, each for one tick. None of them pulses in any other slot or for a pixel that is held off.
- R7: A write (`wr_en` high with `wr_addr`, `wr_data`) changes nothing on the line in progress. It takes effect from the next line start onward.
- R8: A master start, sampled on a clock edge, restarts at slot 0 phase 0 with every pixel counter at zero and the written multiples loaded. Any line in progress is abandoned.
- R9: While reset is asserted, `pix_clk`, `start_pulse` and all strobes are low and `inhibit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mstart | input | 1 | Master start; restarts the sequence |
| wr_en | input | 1 | Multiple write strobe |
| wr_addr | input | AW | Pixel index minus one |
| wr_data | input | MW | Integration multiple M |
| pix_clk | output | 1 | Sensor pixel clock |
| start_pulse | output | 1 | Sensor start pulse |
| inhibit | output | 1 | Active-low read enable, high = pixel held off |
| integ_rst | output | 1 | Integrator reset strobe |
| clamp_stb | output | 1 | Clamp strobe |
| trig_stb | output | 1 | Sample trigger strobe |

## Verification
The bench builds the block with 8 pixels, 2 pad slots, a divide-by-8 pixel clock and a guard of 2 ticks, which gives a 96-tick line. At that size every master tick of dozens of consecutive lines can be compared against arithmetic expectations. Multiples of 0, 1, 2, 3, 4, 5, 7 and 15 are all in play, so a full 15-line wrap fits in one sweep, alongside a mid-line write and a restart taken from an arbitrary phase.

// File: rtl/sens_tg_pkg.sv
package sens_tg_pkg;

    typedef enum logic [1:0] {
        SQ_LEAD = 2'd0,
        SQ_PIX  = 2'd1,
        SQ_EOS  = 2'd2,
        SQ_PAD  = 2'd3
    } seq_state_t;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sens_tg_phase.sv
module sens_tg_phase #(
    parameter int unsigned DIV = 8,
    localparam int unsigned PW = sens_tg_pkg::width_of(DIV)
) (
    input  logic          mclk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [PW-1:0] ph,
    output logic          ph_last
);

    localparam logic [PW-1:0] PH_MAX = PW'(DIV - 1);

    always_ff @(posedge mclk) begin
        if (!rst_n || restart) begin
            ph <= '0;
        end else if (ph == PH_MAX) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    assign ph_last = (ph == PH_MAX);

endmodule

// File: rtl/sens_tg_cfg.sv
module sens_tg_cfg #(
    parameter int unsigned NPIX = 128,
    parameter int unsigned MW   = 4,
    localparam int unsigned AW  = sens_tg_pkg::width_of(NPIX)
) (
    input  logic          mclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [MW-1:0] wr_data,
    input  logic          load,
    input  logic          clr,
    input  logic          adv,
    input  logic [AW-1:0] sel,
    output logic          rd_ok
);

    logic [MW-1:0] shadow_q [NPIX];
    logic [MW-1:0] active_q [NPIX];
    logic [MW-1:0] cnt_q    [NPIX];

    for (genvar gi = 0; gi < NPIX; gi++) begin : g_pix
        logic [MW:0] inc;
        logic [MW:0] lim;
        logic        hit_wr;
        logic        hit_adv;

        assign inc     = {1'b0, cnt_q[gi]} + 1'b1;
        assign lim     = (active_q[gi] == '0) ? (MW+1)'(1) : {1'b0, active_q[gi]};
        assign hit_wr  = wr_en && (wr_addr == AW'(gi));
        assign hit_adv = adv && (sel == AW'(gi));

        always_ff @(posedge mclk) begin
            if (!rst_n) begin
                shadow_q[gi] <= MW'(1);
            end else if (hit_wr) begin
                shadow_q[gi] <= wr_data;
            end
        end

        always_ff @(posedge mclk) begin
            if (!rst_n) begin
                active_q[gi] <= MW'(1);
            end else if (load) begin
                active_q[gi] <= shadow_q[gi];
            end
        end

        always_ff @(posedge mclk) begin
            if (!rst_n || clr) begin
                cnt_q[gi] <= '0;
            end else if (hit_adv) begin
                if (inc >= lim) begin
                    cnt_q[gi] <= '0;
                end else begin
                    cnt_q[gi] <= inc[MW-1:0];
                end
            end
        end
    end

    always_comb begin
        if (32'(sel) < NPIX) begin
            rd_ok = (cnt_q[sel] == '0);
        end else begin
            rd_ok = 1'b0;
        end
    end

endmodule

// File: rtl/sens_tg_seq.sv
module sens_tg_seq
    import sens_tg_pkg::*;
#(
    parameter int unsigned NPIX      = 128,
    parameter int unsigned PAD_SLOTS = 0,
    parameter int unsigned DIV       = 8,
    parameter int unsigned GUARD     = 2,
    localparam int unsigned LINE     = NPIX + 2 + PAD_SLOTS,
    localparam int unsigned SW       = width_of(LINE),
    localparam int unsigned PW       = width_of(DIV),
    localparam int unsigned AW       = width_of(NPIX)
) (
    input  logic          mclk,
    input  logic          rst_n,
    input  logic          mstart,
    input  logic [PW-1:0] ph,
    input  logic          ph_last,
    input  logic          rd_ok,
    output logic [AW-1:0] sel,
    output logic          adv,
    output logic          load,
    output logic          clr,
    output logic          pix_clk,
    output logic          start_pulse,
    output logic          inhibit,
    output logic          integ_rst,
    output logic          clamp_stb,
    output logic          trig_stb
);

    localparam logic [PW-1:0] PH_HALF = PW'(DIV / 2);
    localparam logic [PW-1:0] PH_WLO  = PW'(GUARD);
    localparam logic [PW-1:0] PH_WHI  = PW'(DIV - GUARD - 1);
    localparam logic [PW-1:0] PH_TRIG = PW'(DIV - GUARD);
    localparam logic [SW-1:0] SL_LAST = SW'(LINE - 1);
    localparam logic [SW-1:0] SL_NPIX = SW'(NPIX);

    seq_state_t    state_q, state_d;
    logic [SW-1:0] slot_q, slot_d;
    logic          rd;

    // next-state decision
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        if (mstart) begin
            state_d = SQ_LEAD;
            slot_d  = '0;
        end else if (ph_last) begin
            unique case (state_q)
                SQ_LEAD: begin
                    state_d = SQ_PIX;
                    slot_d  = SW'(1);
                end
                SQ_PIX: begin
                    if (slot_q == SL_NPIX) begin
                        state_d = SQ_EOS;
                    end
                    slot_d = slot_q + 1'b1;
                end
                SQ_EOS: begin
                    if (PAD_SLOTS == 0) begin
                        state_d = SQ_LEAD;
                        slot_d  = '0;
                    end else begin
                        state_d = SQ_PAD;
                        slot_d  = slot_q + 1'b1;
                    end
                end
                SQ_PAD: begin
                    if (slot_q == SL_LAST) begin
                        state_d = SQ_LEAD;
                        slot_d  = '0;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
                default: begin
                    state_d = SQ_LEAD;
                    slot_d  = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            state_q <= SQ_LEAD;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // control towards the multiple bank
    assign sel  = AW'(slot_q - 1'b1);
    assign adv  = ph_last && !mstart && (state_q == SQ_PIX);
    assign clr  = mstart;
    assign load = mstart || (ph_last && (state_d == SQ_LEAD) && (state_q != SQ_LEAD));
    assign rd   = (state_q == SQ_PIX) && rd_ok;

    // registered outputs
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            pix_clk     <= 1'b0;
            start_pulse <= 1'b0;
            inhibit     <= 1'b1;
            integ_rst   <= 1'b0;
            clamp_stb   <= 1'b0;
            trig_stb    <= 1'b0;
        end else begin
            pix_clk <= (ph >= PH_HALF);
            unique case (state_q)
                SQ_LEAD: begin
                    start_pulse <= (ph >= PH_HALF);
                    inhibit     <= 1'b1;
                    integ_rst   <= 1'b0;
                    clamp_stb   <= 1'b0;
                    trig_stb    <= 1'b0;
                end
                SQ_PIX: begin
                    start_pulse <= (slot_q == SW'(1)) && (ph < PH_HALF);
                    inhibit     <= !(rd && (ph >= PH_WLO) && (ph <= PH_WHI));
                    integ_rst   <= rd && (ph == '0);
                    clamp_stb   <= rd && (ph == PW'(1));
                    trig_stb    <= rd && (ph == PH_TRIG);
                end
                SQ_EOS, SQ_PAD: begin
                    start_pulse <= 1'b0;
                    inhibit     <= 1'b1;
                    integ_rst   <= 1'b0;
                    clamp_stb   <= 1'b0;
                    trig_stb    <= 1'b0;
                end
                default: begin
                    start_pulse <= 1'b0;
                    inhibit     <= 1'b1;
                    integ_rst   <= 1'b0;
                    clamp_stb   <= 1'b0;
                    trig_stb    <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sens_tg.sv
module sens_tg #(
    parameter int unsigned NPIX      = 128,
    parameter int unsigned PAD_SLOTS = 0,
    parameter int unsigned DIV       = 8,
    parameter int unsigned GUARD     = 2,
    parameter int unsigned MW        = 4,
    localparam int unsigned AW       = sens_tg_pkg::width_of(NPIX),
    localparam int unsigned PW       = sens_tg_pkg::width_of(DIV)
) (
    input  logic          mclk,
    input  logic          rst_n,
    input  logic          mstart,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [MW-1:0] wr_data,
    output logic          pix_clk,
    output logic          start_pulse,
    output logic          inhibit,
    output logic          integ_rst,
    output logic          clamp_stb,
    output logic          trig_stb
);

    logic [PW-1:0] ph;
    logic          ph_last;
    logic          rd_ok;
    logic [AW-1:0] sel;
    logic          adv;
    logic          load;
    logic          clr;

    sens_tg_phase #(.DIV(DIV)) u_phase (
        .mclk    (mclk),
        .rst_n   (rst_n),
        .restart (mstart),
        .ph      (ph),
        .ph_last (ph_last)
    );

    sens_tg_cfg #(.NPIX(NPIX), .MW(MW)) u_cfg (
        .mclk    (mclk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .clr     (clr),
        .adv     (adv),
        .sel     (sel),
        .rd_ok   (rd_ok)
    );

    sens_tg_seq #(
        .NPIX      (NPIX),
        .PAD_SLOTS (PAD_SLOTS),
        .DIV       (DIV),
        .GUARD     (GUARD)
    ) u_seq (
        .mclk        (mclk),
        .rst_n       (rst_n),
        .mstart      (mstart),
        .ph          (ph),
        .ph_last     (ph_last),
        .rd_ok       (rd_ok),
        .sel         (sel),
        .adv         (adv),
        .load        (load),
        .clr         (clr),
        .pix_clk     (pix_clk),
        .start_pulse (start_pulse),
        .inhibit     (inhibit),
        .integ_rst   (integ_rst),
        .clamp_stb   (clamp_stb),
        .trig_stb    (trig_stb)
    );

endmodule

// File: rtl/sens_tg_chk.sv
module sens_tg_chk (
    input logic mclk,
    input logic rst_n,
    input logic pix_clk,
    input logic start_pulse,
    input logic inhibit,
    input logic integ_rst,
    input logic clamp_stb,
    input logic trig_stb
);

    AST_INT_HIGH_AT_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
        $fell(pix_clk) |-> (inhibit && $past(inhibit))) else $error("inhibit low at clock fall"); // R3

    AST_INT_EDGE_APART: assert property (@(posedge mclk) disable iff (!rst_n)
        ($fell(inhibit) || $rose(inhibit)) |-> $stable(pix_clk)) else $error("inhibit moved with clock"); // R3

    AST_ST_RISE_CLK_HIGH: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(start_pulse) |-> pix_clk) else $error("start rose with clock low"); // R2

    AST_STROBE_EXCL: assert property (@(posedge mclk) disable iff (!rst_n)
        $onehot0({integ_rst, clamp_stb, trig_stb})) else $error("strobes overlap"); // R6

    AST_CLAMP_AFTER_RST: assert property (@(posedge mclk) disable iff (!rst_n)
        integ_rst |=> clamp_stb) else $error("clamp missing after reset strobe"); // R6

    AST_TRIG_INT_HIGH: assert property (@(posedge mclk) disable iff (!rst_n)
        trig_stb |-> (inhibit && !$past(inhibit))) else $error("trigger not at read end"); // R6

endmodule

bind sens_tg sens_tg_chk u_chk (
    .mclk        (mclk),
    .rst_n       (rst_n),
    .pix_clk     (pix_clk),
    .start_pulse (start_pulse),
    .inhibit     (inhibit),
    .integ_rst   (integ_rst),
    .clamp_stb   (clamp_stb),
    .trig_stb    (trig_stb)
);

// File: tb/sens_tg_tb.sv
module sens_tg_tb;

    localparam int NP  = 8;
    localparam int PDS = 2;
    localparam int DV  = 8;
    localparam int GD  = 2;
    localparam int MWD = 4;
    localparam int AWD = 3;
    localparam int LS  = NP + 2 + PDS;
    localparam int LT  = LS * DV;

    logic           mclk = 1'b0;
    logic           rst_n;
    logic           mstart;
    logic           wr_en;
    logic [AWD-1:0] wr_addr;
    logic [MWD-1:0] wr_data;
    logic pix_clk, start_pulse, inhibit, integ_rst, clamp_stb, trig_stb;

    int vec = 0;
    int bad = 0;
    int exp_m [1:NP];
    int base  [1:NP];

    always #5 mclk = ~mclk;

    sens_tg #(
        .NPIX(NP), .PAD_SLOTS(PDS), .DIV(DV), .GUARD(GD), .MW(MWD)
    ) u_dut (
        .mclk(mclk), .rst_n(rst_n), .mstart(mstart),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_clk(pix_clk), .start_pulse(start_pulse), .inhibit(inhibit),
        .integ_rst(integ_rst), .clamp_stb(clamp_stb), .trig_stb(trig_stb)
    );

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
        end
    endtask

    // read on line n: before base the pixel ran with M=1
    function automatic bit reads(input int p, input int n);
        int m;
        m = (exp_m[p] == 0) ? 1 : exp_m[p];
        if (n < base[p]) return 1'b1;
        return ((n - base[p]) % m) == 0;
    endfunction

    task automatic wr(input int addr, input int val);
        @(negedge mclk);
        wr_en   = 1'b1;
        wr_addr = AWD'(addr);
        wr_data = MWD'(val);
        @(negedge mclk);
        wr_en   = 1'b0;
    endtask

    // master start, then compare every tick of the given number of lines
    task automatic sweep(input int lines, input int wtick, input int wpix, input int wval);
        @(negedge mclk);
        mstart = 1'b1;
        @(negedge mclk);
        mstart = 1'b0;
        for (int j = 0; j < lines * LT; j++) begin
            int n, k, ph;
            bit rd, win, pix;
            string tg;
            @(negedge mclk);
            wr_en = 1'b0;
            n   = j / LT;
            k   = (j % LT) / DV;
            ph  = j % DV;
            pix = (k >= 1) && (k <= NP);
            rd  = pix && reads(k, n);
            win = (ph >= GD) && (ph <= DV - GD - 1);
            if (j == 0) begin
                chk("R8", "pix_clk at restart", pix_clk, 1'b0);
                chk("R8", "start at restart", start_pulse, 1'b0);
            end
            if (j == DV / 2) chk("R8", "start half slot", start_pulse, 1'b1);
            chk("R1", "pix_clk", pix_clk, ph >= DV / 2);
            chk("R2", "start_pulse", start_pulse,
                ((k == 0) && (ph >= DV / 2)) || ((k == 1) && (ph < DV / 2)));
            if (!pix) tg = "R4";
            else if (wtick >= 0 && k == wpix) tg = "R7";
            else if (win) tg = "R5";
            else tg = "R3";
            chk(tg, "inhibit", inhibit, !(rd && win));
            chk("R6", "integ_rst", integ_rst, rd && (ph == 0));
            chk("R6", "clamp_stb", clamp_stb, rd && (ph == 1));
            chk("R6", "trig_stb", trig_stb, rd && (ph == DV - GD));
            if (j == wtick) begin
                wr_en   = 1'b1;
                wr_addr = AWD'(wpix - 1);
                wr_data = MWD'(wval);
            end
        end
        @(negedge mclk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mstart = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge mclk);
        chk("R9", "pix_clk", pix_clk, 1'b0);
        chk("R9", "start_pulse", start_pulse, 1'b0);
        chk("R9", "inhibit", inhibit, 1'b1);
        chk("R9", "integ_rst", integ_rst, 1'b0);
        chk("R9", "clamp_stb", clamp_stb, 1'b0);
        chk("R9", "trig_stb", trig_stb, 1'b0);
        rst_n = 1'b1;
        repeat (13) @(negedge mclk);

        // default multiples of 1: every pixel read every line
        for (int p = 1; p <= NP; p++) begin exp_m[p] = 1; base[p] = 0; end
        sweep(3, -1, 0, 0);

        // mixed multiples including 0 and 15; pixel 1 rewritten mid-line 5
        exp_m[1] = 0; exp_m[2] = 2; exp_m[3] = 3; exp_m[4] = 4;
        exp_m[5] = 5; exp_m[6] = 7; exp_m[7] = 1; exp_m[8] = 15;
        for (int p = 1; p <= NP; p++) wr(p - 1, exp_m[p]);
        exp_m[1] = 4; base[1] = 6;
        sweep(16, 5 * LT + 3, 1, 4);

        // restart from an arbitrary phase: all counters cleared
        repeat (37) @(negedge mclk);
        for (int p = 1; p <= NP; p++) base[p] = 0;
        sweep(16, -1, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule